// File: doc/BRIEF.md
# Limit-Compare Interval Counter

This block is a memory-mapped interval counter advanced by a single-cycle enable pulse, `tick`, that stands for a fixed 500 ns timebase. The count occupies a field that starts at bit 9 of the 32-bit register word, and bits 8..0 always read as zero. Software loads a limit. On a tick where the counter equals a non-zero limit, the counter reloads to one count, a sticky reached flag sets and a level interrupt rises. Reading the limit back acknowledges the event. A limit of zero makes the counter free-run: it wraps at the top of its field and never interrupts.

A three-state machine governs the interrupt. `ST_FREE` holds while the limit is zero. `ST_ARMED` holds while a non-zero limit waits for a match. `ST_FIRED` drives the interrupt and the reached flag. The transitions are:

- T_ARM (`ST_FREE` to `ST_ARMED`): a non-zero limit is written at either limit offset.
- T_DISARM (to `ST_FREE`): a zero limit is written at offset 0x0 from any state, or at offset 0x8 from `ST_ARMED`.
- T_FIRE (`ST_ARMED` to `ST_FIRED`): a tick arrives while the counter equals the limit.
- T_ACK (`ST_FIRED` to `ST_ARMED` or `ST_FREE`, chosen by whether the limit is zero): a limit read that does not coincide with a match.
- T_RELOAD (`ST_FIRED` to `ST_ARMED`, or to `ST_FREE` for a zero value): a write at offset 0x0.

Bus requests complete in a single cycle. A read response is registered and appears one cycle after the request.

Top module: `lcmp_timer`

## Requirements
- R1: After reset the limit is zero, the counter reads zero, the state is `ST_FREE` and `irq` is low.
- R2: Each cycle with `tick` high adds 0x200 to the counter word. Bits 8..0 of a counter read are always zero.
- R3: A read at byte offset 0x4 returns the count in bits 30..9 and the reached flag in bit 31. The response comes with `rsp_valid` on the next cycle.
- R4: A write at offset 0x0 stores the data masked with 0x7FFFFE00 as the limit, clears the counter to zero, and clears both the reached flag and `irq`. This write takes priority over a tick in the same cycle.
- R5: A write at offset 0x8 stores the limit with the same mask but leaves the counter, the reached flag and `irq` as they were.
- R6: With a zero limit the counter free-runs. After 0x7FFFFE00 the next tick gives 0, and neither the reached flag nor `irq` ever sets.
- R7: A tick while the counter equals a non-zero limit reloads the counter to 0x200 and sets the reached flag and `irq` in the same cycle.
- R8: A read at offset 0x0 returns the limit in bits 30..0, then clears the reached flag and lowers `irq`.
- R9: A request whose byte enables are not all ones, whose address is not word aligned, or whose offset is 0xC or above has no effect and reads zero. A write at offset 0x4 is also ignored.
- R10: Once acknowledged, the interrupt recurs every limit/512 ticks.
- R11: If a limit read coincides with a matching tick, the match wins: `irq` is high afterwards and the read still returns the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase enable, one pulse per 500 ns |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_be | input | 4 | Byte enables; only 4'hF is accepted |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read response data |
| irq | output | 1 | Level interrupt, high in `ST_FIRED` |

## Verification
A wrong state in the machine shows up on `irq` on the very next clock edge, and in bit 31 of the next counter read. A stuck or mis-stepped count shows up in the first counter read after any tick, as a value that is not a multiple of 0x200 added per tick. A wrong reload or limit compare moves the interrupt edge by at least one tick, so checking `irq` tick by tick around each match catches it in the cycle it happens. Ignored accesses are confirmed by reading the limit and the counter back at once.

// File: rtl/lcmp_pkg.sv
package lcmp_pkg;
    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRED = 2'd2
    } lcmp_state_e;

    // word index of each register (byte offset >> 2)
    localparam logic [1:0] IDX_LIMIT      = 2'd0;
    localparam logic [1:0] IDX_COUNT      = 2'd1;
    localparam logic [1:0] IDX_LIMIT_KEEP = 2'd2;

    localparam int WORD_W = 32;
endpackage

// File: rtl/lcmp_regif.sv
module lcmp_regif
    import lcmp_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [3:0]          req_be,
    input  logic [WORD_W-1:0]   limit_word,
    input  logic [WORD_W-1:0]   count_word,
    output logic                wr_limit_rst,
    output logic                wr_limit_keep,
    output logic                rd_limit_ack,
    output logic                rsp_valid,
    output logic [WORD_W-1:0]   rsp_rdata
);
    localparam int IDX_W = ADDR_W - 2;

    logic             acc_ok;
    logic [IDX_W-1:0] word_idx;
    logic             is_limit, is_count, is_keep;
    logic [WORD_W-1:0] rd_mux;

    assign word_idx = req_addr[ADDR_W-1:2];
    assign acc_ok   = req_valid && (req_be == 4'hF) && (req_addr[1:0] == 2'b00);
    assign is_limit = (word_idx == IDX_W'(IDX_LIMIT));
    assign is_count = (word_idx == IDX_W'(IDX_COUNT));
    assign is_keep  = (word_idx == IDX_W'(IDX_LIMIT_KEEP));

    assign wr_limit_rst  = acc_ok &&  req_write && is_limit;
    assign wr_limit_keep = acc_ok &&  req_write && is_keep;
    assign rd_limit_ack  = acc_ok && !req_write && is_limit;

    always_comb begin
        rd_mux = '0;
        if (acc_ok && !req_write) begin
            if (is_limit)      rd_mux = limit_word;
            else if (is_count) rd_mux = count_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            rsp_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/lcmp_count.sv
module lcmp_count #(
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit_val,
    output logic [CNT_W-1:0] count_q,
    output logic             hit
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic at_limit;

    assign at_limit = (limit_val != '0) && (count_q == limit_val);
    assign hit      = tick && at_limit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (tick) begin
            if (at_limit)               count_q <= CNT_ONE;
            else if (count_q == CNT_TOP) count_q <= '0;
            else                        count_q <= count_q + CNT_ONE;
        end
    end
endmodule

// File: rtl/lcmp_fsm.sv
module lcmp_fsm
    import lcmp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_limit_rst,
    input  logic        wr_limit_keep,
    input  logic        new_limit_zero,
    input  logic        limit_zero,
    input  logic        hit,
    input  logic        rd_limit_ack,
    output lcmp_state_e state_q,
    output logic        irq,
    output logic        reached
);
    lcmp_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (wr_limit_rst) begin
            state_d = new_limit_zero ? ST_FREE : ST_ARMED;          // T_RELOAD / T_DISARM
        end else begin
            unique case (state_q)
                ST_FREE: begin
                    if (wr_limit_keep && !new_limit_zero) state_d = ST_ARMED;   // T_ARM
                end
                ST_ARMED: begin
                    if (hit)                                  state_d = ST_FIRED; // T_FIRE
                    else if (wr_limit_keep && new_limit_zero) state_d = ST_FREE;  // T_DISARM
                end
                ST_FIRED: begin
                    if (!hit && rd_limit_ack)
                        state_d = limit_zero ? ST_FREE : ST_ARMED;            // T_ACK
                end
                default: state_d = ST_FREE;
            endcase
        end
    end

    always_comb begin
        irq     = (state_q == ST_FIRED);
        reached = (state_q == ST_FIRED);
    end
endmodule

// File: rtl/lcmp_timer.sv
module lcmp_timer
    import lcmp_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LSB    = 9,
    parameter int CNT_W  = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              irq
);
    localparam logic [31:0] FIELD_MASK = 32'(((64'd1 << CNT_W) - 64'd1) << LSB);

    logic             wr_limit_rst, wr_limit_keep, rd_limit_ack;
    logic [CNT_W-1:0] limit_q, new_limit, count_q;
    logic             hit, reached;
    logic [31:0]      limit_word, count_word;
    lcmp_state_e      state_q;
    logic             unused_wdata;

    assign new_limit    = req_wdata[LSB +: CNT_W];
    assign unused_wdata = ^(req_wdata & ~FIELD_MASK);

    always_ff @(posedge clk) begin
        if (!rst_n)                            limit_q <= '0;
        else if (wr_limit_rst || wr_limit_keep) limit_q <= new_limit;
    end

    always_comb begin
        limit_word = '0;
        limit_word[LSB +: CNT_W] = limit_q;
        count_word = '0;
        count_word[LSB +: CNT_W] = count_q;
        count_word[31] = reached;
    end

    lcmp_regif #(.ADDR_W(ADDR_W)) u_regif (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_be        (req_be),
        .limit_word    (limit_word),
        .count_word    (count_word),
        .wr_limit_rst  (wr_limit_rst),
        .wr_limit_keep (wr_limit_keep),
        .rd_limit_ack  (rd_limit_ack),
        .rsp_valid     (rsp_valid),
        .rsp_rdata     (rsp_rdata)
    );

    lcmp_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .clear     (wr_limit_rst),
        .limit_val (limit_q),
        .count_q   (count_q),
        .hit       (hit)
    );

    lcmp_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_limit_rst   (wr_limit_rst),
        .wr_limit_keep  (wr_limit_keep),
        .new_limit_zero (new_limit == '0),
        .limit_zero     (limit_q == '0),
        .hit            (hit),
        .rd_limit_ack   (rd_limit_ack),
        .state_q        (state_q),
        .irq            (irq),
        .reached        (reached)
    );
endmodule

// File: rtl/lcmp_timer_chk.sv
module lcmp_timer_chk #(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [3:0]        req_be,
    input logic              irq,
    input logic [CNT_W-1:0]  limit_q,
    input logic [CNT_W-1:0]  count_q
);
    logic full_acc, wr_rst_req, wr_keep_req, rd_lim_req, match_now;

    assign full_acc    = req_valid && (req_be == 4'hF);
    assign wr_rst_req  = full_acc &&  req_write && (req_addr == ADDR_W'(0));
    assign wr_keep_req = full_acc &&  req_write && (req_addr == ADDR_W'(8));
    assign rd_lim_req  = full_acc && !req_write && (req_addr == ADDR_W'(0));
    assign match_now   = tick && (limit_q != '0) && (count_q == limit_q);

    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_rst_req && !match_now && (count_q != '1))
        |=> (count_q == CNT_W'($past(count_q) + 1'b1)));

    a_r4_limit_write_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rst_req |=> (!irq && (count_q == '0)));

    a_r5_keep_preserves: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_keep_req && !tick) |=> ($stable(count_q) && $stable(irq)));

    a_r6_free_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        ((limit_q == '0) && !irq) |=> !irq);

    a_r7_fire_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (match_now && !wr_rst_req) |=> (irq && (count_q == CNT_W'(1))));

    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lim_req && !match_now) |=> !irq);

    a_r9_partial_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_be != 4'hF) && !tick)
        |=> ($stable(limit_q) && $stable(count_q) && $stable(irq)));
endmodule

bind lcmp_timer lcmp_timer_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_be    (req_be),
    .irq       (irq),
    .limit_q   (limit_q),
    .count_q   (count_q)
);

// File: tb/test_lcmp_timer.sv
module test_lcmp_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [3:0]  req_addr = '0, req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, irq;
    logic [31:0] rsp_rdata;

    // narrow instance (3-bit count field) to reach the wrap point quickly
    logic        n_tick = 1'b0, n_req_valid = 1'b0;
    logic        n_rsp_valid, n_irq;
    logic [31:0] n_rsp_rdata;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    lcmp_timer i_lcmp_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
    );

    lcmp_timer #(.CNT_W(3)) i_lcmp_timer_narrow (
        .clk(clk), .rst_n(rst_n), .tick(n_tick),
        .req_valid(n_req_valid), .req_write(1'b0), .req_addr(4'h4),
        .req_be(4'hF), .req_wdata(32'h0),
        .rsp_valid(n_rsp_valid), .rsp_rdata(n_rsp_rdata), .irq(n_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compare each read response against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R3 unexpected response", 32'h1, 32'h0);
            end else begin
                check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
            end
        end
    end

    // driver: one bus request in the cycle that follows, optional tick alongside
    task automatic bus(input logic wr, input logic [3:0] addr, input logic [31:0] data,
                       input logic [3:0] be, input logic tk,
                       input logic [31:0] exp, input string tag);
        req_valid = 1'b1; req_write = wr; req_addr = addr;
        req_wdata = data; req_be = be; tick = tk;
        if (!wr) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; tick = 1'b0;
    endtask

    task automatic rd(input logic [3:0] addr, input logic [31:0] exp, input string tag);
        bus(1'b0, addr, 32'h0, 4'hF, 1'b0, exp, tag);
    endtask

    task automatic wr(input logic [3:0] addr, input logic [31:0] data);
        bus(1'b1, addr, data, 4'hF, 1'b0, 32'h0, "");
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic n_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            n_tick = 1'b1;
            @(negedge clk);
            n_tick = 1'b0;
        end
    endtask

    task automatic n_read(input logic [31:0] exp, input string tag);
        n_req_valid = 1'b1;
        @(negedge clk);
        n_req_valid = 1'b0;
        check(tag, {n_rsp_valid, n_rsp_rdata[30:0]}, {1'b1, exp[30:0]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        rd(4'h0, 32'h0, "R1 limit after reset");
        rd(4'h4, 32'h0, "R1 counter after reset");

        // R2 / R6 free-run counting from reset
        ticks(10);
        rd(4'h4, 32'h0000_1400, "R2 counter after 10 ticks");
        check("R6 no irq in free-run", {31'b0, irq}, 32'h0);

        // R9 ignored accesses
        bus(1'b1, 4'h0, 32'h0000_0800, 4'h7, 1'b0, 32'h0, "");
        rd(4'h0, 32'h0, "R9 partial write left limit");
        rd(4'h4, 32'h0000_1400, "R9 partial write left counter");
        bus(1'b0, 4'h0, 32'h0, 4'h3, 1'b0, 32'h0, "R9 partial read is zero");
        rd(4'hC, 32'h0, "R9 unmapped read is zero");
        wr(4'hC, 32'h0000_0800);
        wr(4'h4, 32'h0);
        rd(4'h1, 32'h0, "R9 misaligned read is zero");
        rd(4'h0, 32'h0, "R9 unmapped write left limit");
        rd(4'h4, 32'h0000_1400, "R9 counter write ignored");

        // R4 mask and counter reset
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, 32'h7FFF_FE00, "R4 limit masked");
        rd(4'h4, 32'h0, "R4 counter cleared");

        // R5 limit update keeps counter
        ticks(3);
        wr(4'h8, 32'h0000_0800);
        rd(4'h4, 32'h0000_0600, "R5 counter kept");
        rd(4'h0, 32'h0000_0800, "R5 limit updated");

        // R7 match
        ticks(1);
        check("R7 no irq before match tick", {31'b0, irq}, 32'h0);
        ticks(1);
        check("R7 irq on match tick", {31'b0, irq}, 32'h1);
        rd(4'h4, 32'h8000_0200, "R3 R7 reload and reached bit");
        check("R8 counter read keeps irq", {31'b0, irq}, 32'h1);

        // R8 acknowledge
        rd(4'h0, 32'h0000_0800, "R8 limit readback");
        check("R8 irq cleared", {31'b0, irq}, 32'h0);
        rd(4'h4, 32'h0000_0200, "R8 reached cleared");

        // R10 period equals limit/512 ticks
        ticks(3);
        check("R10 no irq before period", {31'b0, irq}, 32'h0);
        ticks(1);
        check("R10 irq after period", {31'b0, irq}, 32'h1);
        rd(4'h4, 32'h8000_0200, "R10 reload value");

        // R4 write lowers irq
        wr(4'h0, 32'h0000_0800);
        check("R4 irq lowered", {31'b0, irq}, 32'h0);
        rd(4'h4, 32'h0, "R4 reached and count cleared");

        // R11 match wins over a coincident acknowledge
        ticks(4);
        check("R11 armed before", {31'b0, irq}, 32'h0);
        bus(1'b0, 4'h0, 32'h0, 4'hF, 1'b1, 32'h0000_0800, "R11 read data");
        check("R11 irq kept", {31'b0, irq}, 32'h1);
        rd(4'h4, 32'h8000_0200, "R11 reached kept");

        // R6 zero limit: free-run, no interrupt
        wr(4'h0, 32'h0);
        check("R6 irq low after zero limit", {31'b0, irq}, 32'h0);
        ticks(20);
        check("R6 no irq while free", {31'b0, irq}, 32'h0);
        rd(4'h4, 32'h0000_2800, "R6 free count");

        // R6 wrap at top of field (narrow instance)
        n_ticks(7);
        n_read(32'h0000_0E00, "R6 narrow count at top");
        n_ticks(1);
        n_read(32'h0, "R6 narrow wrap to zero");
        check("R6 narrow no irq", {31'b0, n_irq}, 32'h0);

        @(negedge clk);
        @(negedge clk);
        check("R3 all responses seen", exp_q.size(), 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule